// File: doc/BRIEF.md
# Reset Cause Tracker with Reset-Out Pulse

This block gathers the three ways a small microcontroller can be reset: a level on the external reset input, a single-cycle software reset command, and a single-cycle watchdog expiry request. From them it produces one active-high internal reset for the rest of the chip. It also holds an 8-bit status register that names the cause of the latest reset. When software has set the register's enable bit, each internally caused reset also drives an active-low reset-out pin for a fixed window. The external input never produces that pulse, so the pin can be wired back into the external reset input without forming a loop.

The block is reset asynchronously by a power-on input. That input is released into the clock domain through a short synchronizer. Software reaches the status register through a plain single-register port: a write strobe with write data, and a read value that is always valid. A controller that resets the CPU uses it to report, after each restart, why the restart happened.

Top module: `rst_src_ctrl`

## Requirements
- R1: While `por_n` is low, and for two clock edges after it rises, `sys_rst` is 1, `rst_out_n` is 1 and `reg_rdata` reads 0x01.
- R2: The clock edge that samples `ext_rst_req` high sets `sys_rst` to 1. It stays 1 while the input is held and drops after the first edge that samples the input low. Status bits [2:0] become 3'b001.
- R3: A software request (`sw_rst_req` high for one edge) makes `sys_rst` 1 for exactly 256 cycles from that edge. Status bits [2:0] become 3'b010.
- R4: A watchdog request (`wdt_rst_req`) is honoured straight after power-on with no set-up. It makes `sys_rst` 1 for 256 cycles and sets status bits [2:0] to 3'b100.
- R5: Status bit 7 is the reset-out enable. If it is 1 on the edge of a software or watchdog request, `rst_out_n` is 0 for exactly the same 256 cycles. If it is 0, `rst_out_n` stays 1.
- R6: The external input wins over other causes. An external request on the same edge as an internal one records only 3'b001 and gives no pulse. Internal requests are ignored while the external input is high. An external request during a pulse ends the low level on `rst_out_n` after that edge.
- R7: When software and watchdog requests arrive on the same edge, the watchdog cause (3'b100) is recorded.
- R8: An internal request during a running window restarts the 256-cycle count from the new edge and records the new cause.
- R9: A write changes only bit 7. Bits 6:3 always read 0. Bits 2:0 ignore write data.
- R10: Bit 7 keeps its value across external, software and watchdog resets. Only power-on clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous assert |
| ext_rst_req | input | 1 | External reset level, active high |
| sw_rst_req | input | 1 | Software reset command, one-cycle pulse |
| wdt_rst_req | input | 1 | Watchdog expiry, one-cycle pulse |
| reg_wr | input | 1 | Status register write strobe |
| reg_wdata | input | 8 | Status register write data |
| reg_rdata | output | 8 | Status register read value |
| sys_rst | output | 1 | Internal reset, active high |
| rst_out_n | output | 1 | Reset-out pin, active low |

## Verification
Every result is due one edge after its stimulus. The status flags, the enable bit, the start of `sys_rst` and the start of the `rst_out_n` pulse all change after the edge that samples the request or write. The end of a window comes 256 edges after that edge. Release from power-on takes two edges after `por_n` rises. The bench drives inputs just after the falling edge and compares all outputs against its behavioural model at each following falling edge. Explicit counts of low `rst_out_n` cycles confirm the window length, including when it is restarted or cut short.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
  localparam int STAT_W   = 8;
  localparam int EN_BIT   = 7;
  localparam int CAUSE_W  = 3;
  localparam int RSVD_W   = EN_BIT - CAUSE_W;

  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_EXT = 3'b001,
    CAUSE_SW  = 3'b010,
    CAUSE_WDT = 3'b100
  } cause_e;
endpackage

// File: rtl/rsc_por_sync.sv
module rsc_por_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic por_n,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/rsc_cause_arb.sv
module rsc_cause_arb
  import rsc_pkg::*;
(
  input  logic   ext_req,
  input  logic   sw_req,
  input  logic   wdt_req,
  output logic   evt_ext,
  output logic   evt_int,
  output cause_e int_cause
);
  // external level dominates; watchdog ranks above software
  always_comb begin
    evt_ext   = ext_req;
    evt_int   = !ext_req && (sw_req || wdt_req);
    int_cause = wdt_req ? CAUSE_WDT : CAUSE_SW;
  end
endmodule

// File: rtl/rsc_pulse_timer.sv
module rsc_pulse_timer #(
  parameter int LEN = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic abort,
  input  logic arm_in,
  output logic busy,
  output logic fire
);
  localparam int CNT_W = $clog2(LEN + 1);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(LEN);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             arm_q, arm_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    arm_d  = arm_q;
    cnt_en = abort || start || (cnt_q != '0);
    if (abort) begin
      cnt_d = '0;
      arm_d = 1'b0;
    end else if (start) begin
      cnt_d = LOAD_VAL;
      arm_d = arm_in;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      arm_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
      arm_q <= arm_d;
    end
  end

  assign busy = (cnt_q != '0);
  assign fire = busy && arm_q;
endmodule

// File: rtl/rst_src_ctrl.sv
module rst_src_ctrl
  import rsc_pkg::*;
#(
  parameter int PULSE_LEN   = 256,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              ext_rst_req,
  input  logic              sw_rst_req,
  input  logic              wdt_rst_req,
  input  logic              reg_wr,
  input  logic [STAT_W-1:0] reg_wdata,
  output logic [STAT_W-1:0] reg_rdata,
  output logic              sys_rst,
  output logic              rst_out_n
);
  logic   rst_n_int;
  logic   evt_ext, evt_int;
  cause_e int_cause;
  logic   busy, fire;

  logic   ext_q, ext_d;
  logic   en_q, en_d;
  cause_e cause_q, cause_d;
  logic   stat_en;

  rsc_por_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .por_n     (por_n),
    .rst_n_out (rst_n_int)
  );

  rsc_cause_arb u_arb (
    .ext_req   (ext_rst_req),
    .sw_req    (sw_rst_req),
    .wdt_req   (wdt_rst_req),
    .evt_ext   (evt_ext),
    .evt_int   (evt_int),
    .int_cause (int_cause)
  );

  rsc_pulse_timer #(.LEN(PULSE_LEN)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .start  (evt_int),
    .abort  (evt_ext),
    .arm_in (en_q),
    .busy   (busy),
    .fire   (fire)
  );

  always_comb begin
    ext_d   = ext_rst_req;
    en_d    = reg_wr ? reg_wdata[EN_BIT] : en_q;
    cause_d = cause_q;
    if (evt_ext)      cause_d = CAUSE_EXT;
    else if (evt_int) cause_d = int_cause;
    stat_en = reg_wr || evt_ext || evt_int;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) ext_q <= 1'b0;
    else            ext_q <= ext_d;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      en_q    <= 1'b0;
      cause_q <= CAUSE_EXT;
    end else if (stat_en) begin
      en_q    <= en_d;
      cause_q <= cause_d;
    end
  end

  assign reg_rdata = {en_q, {RSVD_W{1'b0}}, cause_q};
  assign sys_rst   = !rst_n_int || ext_q || busy;
  assign rst_out_n = !fire;
endmodule

// File: rtl/rst_src_ctrl_chk.sv
module rst_src_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ext_rst_req,
  input logic       sw_rst_req,
  input logic       wdt_rst_req,
  input logic       reg_wr,
  input logic [7:0] reg_rdata,
  input logic       sys_rst,
  input logic       rst_out_n
);
  // R5: pin low only inside an internal reset window
  a_r5_out_within_rst: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_out_n |-> sys_rst);

  // R5: pin follows the enable held on the request edge
  a_r5_out_follows_en: assert property (@(posedge clk) disable iff (!rst_n)
    ((sw_rst_req || wdt_rst_req) && !ext_rst_req && !reg_wr)
      |=> (rst_out_n != reg_rdata[7]));

  // R2
  a_r2_ext_resets: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rst_req |=> (sys_rst && reg_rdata[2:0] == 3'b001));

  // R6
  a_r6_ext_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rst_req |=> rst_out_n);

  // R4, R7
  a_r4_wdt_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_rst_req && !ext_rst_req) |=> (sys_rst && reg_rdata[2:0] == 3'b100));

  // R3
  a_r3_sw_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_rst_req && !wdt_rst_req && !ext_rst_req)
      |=> (sys_rst && reg_rdata[2:0] == 3'b010));

  // R9
  a_r9_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[6:3] == 4'b0000);

  // R9: exactly one cause flag at any time
  a_r9_one_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(reg_rdata[2:0]) == 1);

  // R10
  a_r10_en_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> $stable(reg_rdata[7]));
endmodule

bind rst_src_ctrl rst_src_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n_int),
  .ext_rst_req (ext_rst_req),
  .sw_rst_req  (sw_rst_req),
  .wdt_rst_req (wdt_rst_req),
  .reg_wr      (reg_wr),
  .reg_rdata   (reg_rdata),
  .sys_rst     (sys_rst),
  .rst_out_n   (rst_out_n)
);

// File: tb/tb_rst_src_ctrl.sv
module tb_rst_src_ctrl;
  localparam int PULSE = 256;

  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       ext_rst_req = 1'b0;
  logic       sw_rst_req = 1'b0;
  logic       wdt_rst_req = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       sys_rst;
  logic       rst_out_n;

  int    errors = 0;
  int    checks = 0;
  string cur_req = "R1";
  bit    finished = 1'b0;

  always #2 clk = ~clk;

  rst_src_ctrl dut (
    .clk         (clk),
    .por_n       (por_n),
    .ext_rst_req (ext_rst_req),
    .sw_rst_req  (sw_rst_req),
    .wdt_rst_req (wdt_rst_req),
    .reg_wr      (reg_wr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .sys_rst     (sys_rst),
    .rst_out_n   (rst_out_n)
  );

  // behavioural reference model
  int m_rel, m_cnt, m_flags;
  bit m_ext, m_arm, m_en;

  always @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      m_rel = 0; m_cnt = 0; m_flags = 1; m_ext = 0; m_arm = 0; m_en = 0;
    end else if (m_rel < 2) begin
      m_rel = m_rel + 1;
      m_cnt = 0; m_flags = 1; m_ext = 0; m_arm = 0; m_en = 0;
    end else begin
      m_ext = ext_rst_req;
      if (ext_rst_req) begin
        m_flags = 1; m_cnt = 0; m_arm = 0;
      end else if (sw_rst_req || wdt_rst_req) begin
        m_flags = wdt_rst_req ? 4 : 2;
        m_cnt = PULSE;
        m_arm = m_en;
      end else if (m_cnt > 0) begin
        m_cnt = m_cnt - 1;
      end
      if (reg_wr) m_en = reg_wdata[7];
    end
  end

  function automatic bit exp_sys();
    return (m_rel < 2) || m_ext || (m_cnt > 0);
  endfunction
  function automatic bit exp_out_n();
    return !((m_cnt > 0) && m_arm);
  endfunction
  function automatic int exp_rd();
    return (int'(m_en) << 7) | m_flags;
  endfunction

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!finished) begin
      checks++;
      if (sys_rst !== exp_sys() || rst_out_n !== exp_out_n() ||
          reg_rdata !== 8'(exp_rd())) begin
        errors++;
        $display("FAIL %s cycle-compare: act sys=%0b out_n=%0b rd=%02h exp sys=%0b out_n=%0b rd=%02h",
                 cur_req, sys_rst, rst_out_n, reg_rdata, exp_sys(), exp_out_n(), exp_rd());
      end
    end
  end

  // length of the most recent low stretch on rst_out_n
  int low_run = 0;
  int last_low = 0;
  always @(negedge clk) begin
    if (!rst_out_n) low_run++;
    else if (low_run != 0) begin
      last_low = low_run;
      low_run = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic pulse_req(input bit sw, input bit wdt, input bit ext);
    sw_rst_req = sw; wdt_rst_req = wdt; ext_rst_req = ext;
    cyc(1);
    sw_rst_req = 0; wdt_rst_req = 0; ext_rst_req = 0;
  endtask

  task automatic write_reg(input logic [7:0] d);
    reg_wr = 1; reg_wdata = d;
    cyc(1);
    reg_wr = 0; reg_wdata = 8'h00;
  endtask

  task automatic summary();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    errors++; checks++;
    $display("FAIL watchdog: act=running exp=finished");
    summary();
  end

  initial begin
    // R1: power-on
    cur_req = "R1";
    cyc(3);
    chk(sys_rst === 1'b1 && rst_out_n === 1'b1 && reg_rdata === 8'h01,
        "R1", "held in power-on", int'(reg_rdata), 1);
    por_n = 1'b1;
    cyc(1);
    chk(sys_rst === 1'b1, "R1", "sys_rst one edge after release", int'(sys_rst), 1);
    cyc(1);
    chk(sys_rst === 1'b0, "R1", "sys_rst two edges after release", int'(sys_rst), 0);

    // R4: watchdog honoured at once, enable clear -> no pulse (R5)
    cur_req = "R4";
    pulse_req(0, 1, 0);
    chk(reg_rdata === 8'h04, "R4", "watchdog flag", int'(reg_rdata), 4);
    cyc(PULSE - 1);
    chk(sys_rst === 1'b1, "R4", "last window cycle", int'(sys_rst), 1);
    chk(last_low == 0 && rst_out_n === 1'b1, "R5", "no pulse when disabled", last_low, 0);
    cyc(1);
    chk(sys_rst === 1'b0, "R4", "window ended", int'(sys_rst), 0);

    // R9: register writes
    cur_req = "R9";
    write_reg(8'hFF);
    chk(reg_rdata === 8'h84, "R9", "write all ones", int'(reg_rdata), 'h84);
    write_reg(8'h7B);
    chk(reg_rdata === 8'h04, "R9", "write clears enable only", int'(reg_rdata), 4);
    write_reg(8'h80);
    chk(reg_rdata === 8'h84, "R9", "enable set", int'(reg_rdata), 'h84);

    // R3 / R5: software request, 256-cycle pulse
    cur_req = "R3";
    pulse_req(1, 0, 0);
    chk(reg_rdata === 8'h82 && !rst_out_n, "R3", "sw flag and pulse start", int'(reg_rdata), 'h82);
    cyc(PULSE + 2);
    chk(last_low == PULSE, "R5", "pulse length", last_low, PULSE);
    chk(sys_rst === 1'b0, "R3", "window over", int'(sys_rst), 0);

    // R8: restart mid-window
    cur_req = "R8";
    pulse_req(1, 0, 0);
    cyc(99);
    pulse_req(0, 1, 0);
    chk(reg_rdata === 8'h84, "R8", "cause updated", int'(reg_rdata), 'h84);
    cyc(PULSE + 2);
    chk(last_low == 100 + PULSE, "R8", "restarted low length", last_low, 100 + PULSE);

    // R7: both internal causes together
    cur_req = "R7";
    pulse_req(1, 1, 0);
    chk(reg_rdata === 8'h84, "R7", "watchdog wins", int'(reg_rdata), 'h84);
    cyc(PULSE + 2);

    // R6: external together with internal
    cur_req = "R6";
    last_low = 0;
    pulse_req(1, 1, 1);
    chk(reg_rdata === 8'h81 && rst_out_n === 1'b1, "R6", "external precedence", int'(reg_rdata), 'h81);
    cyc(PULSE + 2);
    chk(last_low == 0, "R6", "no pulse from external", last_low, 0);

    // R6: external cuts a running pulse
    pulse_req(1, 0, 0);
    cyc(9);
    pulse_req(0, 0, 1);
    chk(rst_out_n === 1'b1 && sys_rst === 1'b1, "R6", "pulse cut", int'(rst_out_n), 1);
    cyc(2);
    chk(last_low == 10, "R6", "cut pulse length", last_low, 10);

    // R2 / R6: external held, internal requests ignored
    cur_req = "R2";
    ext_rst_req = 1;
    cyc(4);
    sw_rst_req = 1;
    cyc(1);
    sw_rst_req = 0;
    cyc(5);
    chk(sys_rst === 1'b1 && reg_rdata === 8'h81, "R2", "held external", int'(reg_rdata), 'h81);
    ext_rst_req = 0;
    cyc(1);
    chk(sys_rst === 1'b0 && rst_out_n === 1'b1, "R6", "request ignored under external", int'(sys_rst), 0);

    // R10: enable survives internal and external resets
    cur_req = "R10";
    chk(reg_rdata[7] === 1'b1, "R10", "enable kept", int'(reg_rdata[7]), 1);
    write_reg(8'h00);
    pulse_req(1, 0, 0);
    cyc(PULSE + 2);
    chk(rst_out_n === 1'b1 && reg_rdata === 8'h02, "R5", "disabled sw request", int'(reg_rdata), 2);
    write_reg(8'h80);
    cyc(1);
    por_n = 1'b0;
    cyc(2);
    chk(reg_rdata === 8'h01, "R10", "power-on clears enable", int'(reg_rdata), 1);
    por_n = 1'b1;
    cyc(3);
    chk(sys_rst === 1'b0 && reg_rdata === 8'h01, "R1", "second release", int'(reg_rdata), 1);

    summary();
  end
endmodule